// File: doc/BRIEF.md
# Interrupt Restart Vector Injector

This block collects up to eight interrupt request lines for an 8-bit processor and presents them as one request. It drives that request only while the processor reports that its interrupts are enabled. The processor answers with an interrupt-acknowledge fetch, which is marked by bit 0 of the status byte the processor shows with its sync pulse. The block then captures the highest-priority pending line. While the processor holds its read strobe, the block places a one-byte restart instruction on the data bus. The instruction names the handler, and the handlers sit eight bytes apart from address 00h up to 38h.

Each request line is edge-captured into a pending bit. That bit stays set until its own acknowledge completes, which happens when the read strobe falls. Line 0 has the highest priority and line 7 the lowest. The winner is frozen when the acknowledge begins, so a request that arrives during the read cannot change the byte on the bus. Outside the acknowledge read the block releases the bus: its output enable is low and its data output is held at zero.

Top module: `rst_vector_injector`

## Requirements
- R1: A rising edge on any request line sets that line's pending bit at the next clock edge. The bit stays set until an acknowledge serves that same line.
- R2: `irq_out` is high only when `cpu_ie` is high, at least one bit is pending, and no acknowledge is in progress.
- R3: A clock edge with `stat_sync` high and `stat_byte[0]` high starts an acknowledge and captures the lowest-numbered pending line as the winner.
- R4: During the acknowledge, while `rd_strobe` is high, `data_oe` is high and `data_out` carries the restart opcode `{2'b11, n[2:0], 3'b111}`, where n is the winner. The handler address is n*8, so the opcodes are C7h, CFh, D7h, DFh, E7h, EFh, F7h and FFh for n = 0 to 7.
- R5: At all other times `data_oe` is low and `data_out` is 8'h00.
- R6: The opcode stays unchanged for the whole read, even if a higher-priority line rises during it.
- R7: The first clock edge that sees `rd_strobe` low after it was high ends the acknowledge. That edge clears only the winner's pending bit, and other pending bits are kept.
- R8: An acknowledge that starts with nothing pending supplies FFh (n = 7) and clears nothing.
- R9: A sync edge with `stat_byte[0]` low cancels any acknowledge in progress. A later read then leaves the bus undriven.
- R10: A line that stays high after it has been served raises no new request until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Request lines, index 0 highest priority |
| cpu_ie | input | 1 | Processor interrupt-enable output |
| stat_sync | input | 1 | Marks the cycle in which the status byte is valid |
| stat_byte | input | 8 | Processor status byte; bit 0 marks an acknowledge fetch |
| rd_strobe | input | 1 | Processor data-in strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Opcode byte for the data bus |
| data_oe | output | 1 | Data bus drive enable |

## Verification
A line edge first shows on `irq_out` right after the next clock edge, so the bench drives every input 1 ns after a rising edge and samples after the following one. The acknowledge is captured on the sync edge. From then on the opcode and its enable follow `rd_strobe` combinationally, so they are checked in the same cycle that the strobe is raised. The pending bit is cleared on the first edge that sees the strobe low. The bench therefore checks the freed and kept requests through `irq_out` and through a second acknowledge, one edge after the strobe falls.

// File: rtl/rst_vector_injector.sv
module rst_vector_injector #(
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(1<<IDX_W)-1:0] irq_lines,
  input  logic                 cpu_ie,
  input  logic                 stat_sync,
  input  logic [7:0]           stat_byte,
  input  logic                 rd_strobe,
  output logic                 irq_out,
  output logic [7:0]           data_out,
  output logic                 data_oe
);
  localparam int NL = 1 << IDX_W;

  logic [NL-1:0]    line_q, pend;
  logic             in_ack, rd_q;
  logic [IDX_W-1:0] win_idx, best;
  logic             ack_go, ack_done;

  always_comb begin
    best = '1;
    for (int i = NL-1; i >= 0; i--)
      if (pend[i]) best = IDX_W'(i);
  end

  assign ack_go   = stat_sync & stat_byte[0];
  assign ack_done = in_ack & rd_q & ~rd_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      pend    <= '0;
      in_ack  <= 1'b0;
      rd_q    <= 1'b0;
      win_idx <= '0;
    end else begin
      line_q <= irq_lines;
      rd_q   <= rd_strobe;
      pend   <= (pend & ~((ack_done & pend[win_idx]) ? (NL'(1) << win_idx) : '0))
                | (irq_lines & ~line_q);
      if (ack_go) begin
        in_ack  <= 1'b1;
        win_idx <= best;
      end else if (stat_sync || ack_done) begin
        in_ack  <= 1'b0;
      end
    end
  end

  assign irq_out  = cpu_ie & (|pend) & ~in_ack;
  assign data_oe  = in_ack & rd_strobe;
  assign data_out = data_oe ? {2'b11, win_idx, 3'b111} : 8'h00;

  a_r2_gate_ie: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ie |-> !irq_out);
  a_r2_quiet_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !irq_out);
  a_r4_opcode_form: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out[7:6] == 2'b11 && data_out[2:0] == 3'b111));
  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == 8'h00);
  a_r6_stable_read: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_out));
  a_r9_no_drive_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |-> !data_oe);
endmodule

// File: tb/tb_rst_vector_injector.sv
module tb_rst_vector_injector;
  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_lines = 0, stat_byte = 0;
  logic       cpu_ie = 0, stat_sync = 0, rd_strobe = 0;
  logic       irq_out, data_oe;
  logic [7:0] data_out;
  int total = 0, bad = 0;
  bit done = 0;

  rst_vector_injector dut (.*);

  always #4 clk = ~clk;

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ack_start(logic bit0 = 1'b1);
    stat_sync = 1; stat_byte = bit0 ? 8'h23 : 8'h82;
    step();
    stat_sync = 0; stat_byte = 0;
  endtask

  task automatic ack_read(string tag, logic [7:0] exp_op);
    rd_strobe = 1;
    #1;
    chk({tag, " oe"}, data_oe, 1);
    chk({tag, " opcode"}, data_out, exp_op);
    step();
    chk({tag, " opcode held"}, data_out, exp_op);
    rd_strobe = 0;
    step();
    chk({tag, " bus released"}, {data_oe, data_out}, 0);
  endtask

  task automatic pulse(logic [7:0] m);
    irq_lines = irq_lines | m; step();
    irq_lines = irq_lines & ~m; step();
  endtask

  task automatic t_reset;
    chk("R5 reset oe/data", {data_oe, data_out}, 0);
    chk("R2 reset irq", irq_out, 0);
  endtask

  task automatic t_single;
    cpu_ie = 1;
    pulse(8'h20);
    chk("R1 pending raises irq", irq_out, 1);
    ack_start();
    chk("R2 irq low during ack", irq_out, 0);
    ack_read("R4 line5", 8'hEF);
    chk("R7 served bit cleared", irq_out, 0);
  endtask

  task automatic t_priority;
    pulse(8'h24);
    ack_start();
    ack_read("R3 lowest wins", 8'hD7);
    chk("R7 other kept", irq_out, 1);
    ack_start();
    ack_read("R4 line5 second", 8'hEF);
    chk("R7 all served", irq_out, 0);
  endtask

  task automatic t_disabled;
    cpu_ie = 0;
    pulse(8'h80);
    chk("R2 masked by ie", irq_out, 0);
    cpu_ie = 1; #1;
    chk("R1 held while disabled", irq_out, 1);
    ack_start();
    ack_read("R4 line7", 8'hFF);
    chk("R7 line7 cleared", irq_out, 0);
  endtask

  task automatic t_stable;
    pulse(8'h08);
    ack_start();
    rd_strobe = 1; step();
    irq_lines = 8'h01; step();
    chk("R6 opcode stable", data_out, 8'hDF);
    rd_strobe = 0; step();
    irq_lines = 0;
    chk("R7 new request pending", irq_out, 1);
    ack_start();
    ack_read("R3 late line0", 8'hC7);
    chk("R7 none left", irq_out, 0);
  endtask

  task automatic t_empty;
    ack_start();
    ack_read("R8 empty ack", 8'hFF);
    chk("R8 nothing raised", irq_out, 0);
    pulse(8'h02);
    ack_start();
    ack_read("R8 line1 after empty", 8'hCF);
  endtask

  task automatic t_cancel;
    pulse(8'h10);
    ack_start();
    ack_start(1'b0);
    rd_strobe = 1; #1;
    chk("R9 read after cancel undriven", {data_oe, data_out}, 0);
    step(); rd_strobe = 0; step();
    chk("R9 request still pending", irq_out, 1);
    ack_start();
    ack_read("R9 line4 later", 8'hE7);
  endtask

  task automatic t_level;
    irq_lines = 8'h40; step();
    ack_start();
    ack_read("R10 line6", 8'hF7);
    step(3);
    chk("R10 held line no re-request", irq_out, 0);
    irq_lines = 0; step();
    irq_lines = 8'h40; step();
    chk("R10 new edge requests", irq_out, 1);
    irq_lines = 0;
    ack_start();
    ack_read("R10 line6 again", 8'hF7);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1; step();
    t_single();
    t_priority();
    t_disabled();
    t_stable();
    t_empty();
    t_cancel();
    t_level();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule